// File: doc/BRIEF.md
# Halfword Instruction Queue for Mixed-Length Code

This block sits between an instruction fetch unit and a decoder in a core that runs 16-bit compressed and 32-bit instructions side by side. The fetch side delivers aligned 32-bit words. The queue splits each word into two halfwords and appends them at its tail, the low halfword first. On the decode side, the queue looks at the halfword at its head and uses the two lowest bits of that halfword to decide the instruction length. It then hands one whole instruction to the decoder through a valid/ready handshake.

A 16-bit instruction takes one halfword from the queue. A 32-bit instruction takes two. A 32-bit instruction is only offered once both of its halves are held, so an instruction whose halves come from two different fetch words is joined with no help from the decoder. The queue raises a refill request while it holds less than one full 32-bit word. A flush input empties the queue at once, for example after a redirect.

Top module: `iqh_queue`

## Requirements
- R1: The instruction length is decided by bits [1:0] of the head halfword. The value 2'b11 means a 32-bit instruction and any other value means a 16-bit one. `inst_is16` is high exactly when a 16-bit instruction is offered.
- R2: A 16-bit instruction is offered as `{16'h0000, head}` and a pop removes one halfword.
- R3: For a 32-bit instruction, the earlier halfword appears on `inst_data[15:0]` and the later halfword on `inst_data[31:16]`. A pop removes both halfwords.
- R4: `inst_valid` stays low while the head marks a 32-bit instruction and only one halfword is held.
- R5: In an accepted fetch word, bits [15:0] are queued ahead of bits [31:16].
- R6: `fetch_ready` is high exactly when at least two of the DEPTH halfword slots are free. A word offered while `fetch_ready` is low is not stored.
- R7: `fetch_req` is high exactly when fewer than two halfwords are held.
- R8: An asserted `flush` empties the queue by the next cycle. A fetch word and a pop presented in the same cycle as the flush both have no effect.
- R9: A push and a pop in the same cycle are both carried out, and the queue keeps program order.
- R10: While `inst_valid` is high and `inst_ready` is low, the offered instruction stays unchanged. This holds even if a push happens in the same cycle.
- R11: After reset the queue is empty. `inst_valid` is low, and both `fetch_req` and `fetch_ready` are high.
- R12: The queue never holds more than DEPTH halfwords.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empties the queue and cancels the same-cycle push and pop |
| fetch_valid | input | 1 | A fetch word is offered |
| fetch_word | input | 32 | Aligned fetch word; the low halfword comes first |
| fetch_ready | output | 1 | At least two halfword slots are free |
| fetch_req | output | 1 | Fewer than two halfwords are held; requests a refill |
| inst_valid | output | 1 | A complete instruction is offered |
| inst_ready | input | 1 | The decoder takes the offered instruction |
| inst_data | output | 32 | The instruction; a 16-bit instruction is zero-extended |
| inst_is16 | output | 1 | The offered instruction is 16 bits long |

## Verification
The bench builds the queue with its default depth of four halfwords. At that depth, two fetch words fill the queue, so backpressure, a rejected word and pointer wrap-around each come up within a few cycles. The same setting also makes it easy to create a 32-bit instruction whose halves come from two fetch words: a 16-bit instruction followed by the lower half of a 32-bit one. With that pattern the bench checks the wait for the second half and the joined result, and it also covers a push and a pop in the same cycle and a flush that collides with both a push and a pop.

// File: rtl/iqh_pkg.sv
package iqh_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/iqh_len_dec.sv
module iqh_len_dec
    import iqh_pkg::*;
(
    input  half_t head,
    output logic  wide
);
    // Both low bits set: first half of a 32-bit instruction.
    always_comb begin
        wide = (head[1:0] == 2'b11);
    end
endmodule

// File: rtl/iqh_store.sv
module iqh_store
    import iqh_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_ptr,
    input  word_t         wr_word,
    input  logic [PW-1:0] rd_ptr,
    output half_t         head0,
    output half_t         head1
);
    half_t mem_d [DEPTH];
    half_t mem_q [DEPTH];

    logic [PW-1:0] wr_nxt;
    logic [PW-1:0] rd_nxt;

    always_comb begin
        wr_nxt = wr_ptr + PW'(1);
        rd_nxt = rd_ptr + PW'(1);
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_ptr] = wr_word[HALF_W-1:0];
            mem_d[wr_nxt] = wr_word[WORD_W-1:HALF_W];
        end
        head0 = mem_q[rd_ptr];
        head1 = mem_q[rd_nxt];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end
endmodule

// File: rtl/iqh_queue.sv
module iqh_queue
    import iqh_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_word,
    output logic        fetch_ready,
    output logic        fetch_req,
    output logic        inst_valid,
    input  logic        inst_ready,
    output logic [31:0] inst_data,
    output logic        inst_is16
);
    // DEPTH must be a power of two, at least 2, so the pointers wrap on their own.
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FREE_LIM = CW'(DEPTH - 2);
    localparam logic [CW-1:0] TWO      = CW'(2);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    half_t head0, head1;
    logic  head_wide;
    logic  push, pop;
    logic [CW-1:0] add_n, sub_n;

    iqh_len_dec i_len_dec (
        .head (head0),
        .wide (head_wide)
    );

    iqh_store #(.DEPTH(DEPTH)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_ptr  (ctl_q.wr),
        .wr_word (fetch_word),
        .rd_ptr  (ctl_q.rd),
        .head0   (head0),
        .head1   (head1)
    );

    always_comb begin
        fetch_ready = (ctl_q.cnt <= FREE_LIM);
        fetch_req   = (ctl_q.cnt < TWO);
        inst_valid  = (ctl_q.cnt != '0) && (!head_wide || ctl_q.cnt >= TWO);
        inst_is16   = !head_wide;
        inst_data   = head_wide ? {head1, head0} : {{HALF_W{1'b0}}, head0};

        push  = fetch_valid && fetch_ready && !flush;
        pop   = inst_valid && inst_ready && !flush;
        add_n = push ? TWO : '0;
        sub_n = pop ? (head_wide ? TWO : CW'(1)) : '0;

        ctl_d = ctl_q;
        if (flush) begin
            ctl_d = '0;
        end else begin
            ctl_d.rd  = ctl_q.rd + PW'(sub_n);
            ctl_d.wr  = ctl_q.wr + PW'(add_n);
            ctl_d.cnt = ctl_q.cnt + add_n - sub_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) ctl_q.cnt <= CW'(DEPTH)); // R12
    AST_WIDE_WHOLE: assert property (@(posedge clk) disable iff (!rst_n) (inst_valid && !inst_is16) |-> (ctl_q.cnt >= TWO)); // R4
    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (!inst_valid && fetch_req && fetch_ready)); // R8
    AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n) (inst_valid && !inst_ready && !flush) |=> (inst_valid && $stable(inst_data))); // R10
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n) (fetch_valid && !fetch_ready && !flush) |=> (ctl_q.cnt <= $past(ctl_q.cnt))); // R6
endmodule

// File: tb/test_iqh_queue.sv
module test_iqh_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_word = '0;
    logic        fetch_ready;
    logic        fetch_req;
    logic        inst_valid;
    logic        inst_ready = 1'b0;
    logic [31:0] inst_data;
    logic        inst_is16;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    iqh_queue i_iqh_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .fetch_valid (fetch_valid),
        .fetch_word  (fetch_word),
        .fetch_ready (fetch_ready),
        .fetch_req   (fetch_req),
        .inst_valid  (inst_valid),
        .inst_ready  (inst_ready),
        .inst_data   (inst_data),
        .inst_is16   (inst_is16)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec = n_vec + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [31:0] w);
        fetch_valid = 1'b1;
        fetch_word  = w;
        step();
        fetch_valid = 1'b0;
    endtask

    task automatic pop();
        inst_ready = 1'b1;
        step();
        inst_ready = 1'b0;
    endtask

    task automatic expect16(input string req, input logic [15:0] h);
        chk({req, " valid"}, 32'(inst_valid), 32'd1);
        chk({req, " is16"}, 32'(inst_is16), 32'd1);
        chk({req, " data"}, inst_data, {16'h0, h});
    endtask

    task automatic expect32(input string req, input logic [31:0] w);
        chk({req, " valid"}, 32'(inst_valid), 32'd1);
        chk({req, " is16"}, 32'(inst_is16), 32'd0);
        chk({req, " data"}, inst_data, w);
    endtask

    task automatic t_reset();
        chk("R11 valid", 32'(inst_valid), 32'd0);
        chk("R11 req", 32'(fetch_req), 32'd1);
        chk("R11 ready", 32'(fetch_ready), 32'd1);
    endtask

    task automatic t_short_pair();
        push(32'h1235_4560);
        expect16("R1 R2 R5 first", 16'h4560);
        chk("R7 two held", 32'(fetch_req), 32'd0);
        pop();
        expect16("R5 second", 16'h1235);
        chk("R7 one held", 32'(fetch_req), 32'd1);
        pop();
        chk("R2 empty", 32'(inst_valid), 32'd0);
    endtask

    task automatic t_wide();
        push(32'hABCD_1233);
        expect32("R1 R3 wide", 32'hABCD_1233);
        pop();
        chk("R3 both taken", 32'(inst_valid), 32'd0);
        chk("R3 req", 32'(fetch_req), 32'd1);
    endtask

    task automatic t_straddle();
        push(32'h0013_0008);
        expect16("R2 before straddle", 16'h0008);
        pop();
        chk("R4 half only", 32'(inst_valid), 32'd0);
        chk("R7 half only", 32'(fetch_req), 32'd1);
        push(32'h2222_BEEF);
        expect32("R3 straddle joined", 32'hBEEF_0013);
        pop();
        expect16("R2 tail", 16'h2222);
        pop();
        chk("R4 drained", 32'(inst_valid), 32'd0);
    endtask

    task automatic t_full();
        push(32'h2220_1110);
        push(32'h4440_3330);
        chk("R6 full ready", 32'(fetch_ready), 32'd0);
        chk("R7 full req", 32'(fetch_req), 32'd0);
        push(32'h6660_5550);
        expect16("R12 head kept", 16'h1110);
        pop();
        chk("R6 one free", 32'(fetch_ready), 32'd0);
        pop();
        chk("R6 two free", 32'(fetch_ready), 32'd1);
        expect16("R6 third", 16'h3330);
        pop();
        expect16("R6 fourth", 16'h4440);
        pop();
        chk("R6 rejected word absent", 32'(inst_valid), 32'd0);
    endtask

    task automatic t_simul();
        push(32'h0101_0202);
        fetch_valid = 1'b1;
        fetch_word  = 32'h0404_0300;
        inst_ready  = 1'b1;
        step();
        fetch_valid = 1'b0;
        inst_ready  = 1'b0;
        expect16("R9 after both", 16'h0101);
        pop();
        expect16("R9 new low", 16'h0300);
        pop();
        expect16("R9 new high", 16'h0404);
        pop();
        chk("R9 drained", 32'(inst_valid), 32'd0);
    endtask

    task automatic t_flush();
        push(32'h7770_7771);
        flush       = 1'b1;
        fetch_valid = 1'b1;
        fetch_word  = 32'h8880_8881;
        inst_ready  = 1'b1;
        step();
        flush       = 1'b0;
        fetch_valid = 1'b0;
        inst_ready  = 1'b0;
        chk("R8 empty", 32'(inst_valid), 32'd0);
        chk("R8 req", 32'(fetch_req), 32'd1);
        step();
        chk("R8 push dropped", 32'(inst_valid), 32'd0);
        push(32'h9990_9992);
        expect16("R8 fresh head", 16'h9992);
        pop();
        pop();
    endtask

    task automatic t_stall();
        push(32'hCAFE_F00F);
        expect32("R10 offered", 32'hCAFE_F00F);
        push(32'h5550_5551);
        expect32("R10 held after push", 32'hCAFE_F00F);
        step();
        expect32("R10 held idle", 32'hCAFE_F00F);
        pop();
        expect16("R10 next", 16'h5551);
        pop();
        expect16("R10 last", 16'h5550);
        pop();
        chk("R10 drained", 32'(inst_valid), 32'd0);
    endtask

    initial begin
        step();
        step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_short_pair();
        t_wide();
        t_straddle();
        t_full();
        t_simul();
        t_flush();
        t_stall();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule